// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block moves single bytes across the monitor slot of a frame-synchronous serial TDM bus. Each bus frame carries one data byte slot and two active-low handshake bits: a send-handshake bit, pulled low by the side that offers a byte, and an acknowledge-handshake bit, pulled low by the side that takes it. Bytes do not flow at a fixed rate. A byte that is offered is sent again in every frame until the far end acknowledges it, and a message ends when the sender leaves its send-handshake bit high for two frames in a row.

The block works at the frame level. A one-cycle frame strobe marks the instant at which the far end's bits and byte are sampled. The block's own bits and byte are updated at that same clock edge and held for the whole frame. Shifting bits on the wire is done elsewhere. On the host side there is a small register port with four registers: control, transmit data, status and receive data. There is also one interrupt line. Sticky event flags clear when the status register is read.

The sender and the receiver each have their own enable. While an enable is clear, the matching handshake output is held at the idle value 1 and that side of the protocol stays in its idle state.

Top module: `mon_hs_ctrl`

## Requirements
- R1: After reset, `snd_hs_o` and `ack_hs_o` are 1, `data_o` is all ones, `irq_o` is 0, and the status register (address 2) reads 0.
- R2: Control register (address 0) bit 0 is the send enable. While it is 0, `snd_hs_o` is 1 and a byte written to address 1 is dropped. It is not sent, even after the enable is set again. Clearing the enable during a transfer drives `snd_hs_o` to 1 one clock after the write.
- R3: With the send enable set, a byte written to address 1 is placed on `data_o`, with `snd_hs_o` = 0, at the next frame strobe. The same byte is repeated every frame until it is acknowledged.
- R4: While a byte is being sent, `far_ack_hs_i` = 0 at two consecutive frame strobes counts as an acknowledge. At the second of those strobes `snd_hs_o` returns to 1, and status bit 0 (acknowledged) is set.
- R5: After an acknowledge, the sender waits for a frame with `far_ack_hs_i` = 1. If a byte was written in the meantime, it goes out at that frame. If no byte was written, the message ends there.
- R6: While sending, if `far_ack_hs_i` is 0 at one strobe and 1 at the next, this is an abort. Status bit 1 (aborted) is set, `snd_hs_o` returns to 1, and status bit 2 clears.
- R7: Status bit 2 (busy) is set when a byte is written with the send enable on. It stays set until the message ends, an abort occurs, or the send enable is cleared.
- R8: Control bit 2 is the receive enable. While it is 0, `ack_hs_o` is 1 and no byte is accepted.
- R9: A byte is accepted only after the same value has been seen with `far_snd_hs_i` = 0 at two consecutive strobes. A differing value restarts the comparison. On acceptance the byte appears at address 3, status bit 4 (received) is set, and `ack_hs_o` goes to 0.
- R10: `ack_hs_o` stays 0 until a strobe sees `far_snd_hs_i` = 1, and then returns to 1. Frames that repeat the byte while `ack_hs_o` is 0 are not accepted a second time.
- R11: After the strobe at which `ack_hs_o` returned to 1, two further consecutive strobes with `far_snd_hs_i` = 1 set status bit 5 (end of message).
- R12: Reading address 2 clears status bits 0, 1, 4 and 5. Bit 2 is not affected by the read.
- R13: `irq_o` = (control bit 1 AND (status bit 0 OR bit 1)) OR (control bit 3 AND (status bit 4 OR bit 5)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | One-cycle strobe per bus frame |
| far_snd_hs_i | input | 1 | Far end's send-handshake bit (active low) |
| far_ack_hs_i | input | 1 | Far end's acknowledge-handshake bit (active low) |
| data_i | input | DATA_W | Monitor byte received this frame |
| snd_hs_o | output | 1 | Own send-handshake bit (active low) |
| ack_hs_o | output | 1 | Own acknowledge-handshake bit (active low) |
| data_o | output | DATA_W | Monitor byte to transmit, all ones when idle |
| host_addr_i | input | 2 | Register select: 0 control, 1 tx data, 2 status, 3 rx data |
| host_wr_i | input | 1 | Register write strobe |
| host_rd_i | input | 1 | Register read strobe (clears flags on address 2) |
| host_wdata_i | input | DATA_W | Write data |
| host_rdata_o | output | DATA_W | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default DATA_W of 8. With that width, random bytes cover the full byte range, including the all-ones idle pattern on the data lines. The six status bits and four control bits also fit inside the host word. Random byte values are combined with random counts of stalled frames on the sending side and random counts of mismatching frames before a stable pair on the receiving side. Directed sequences cover the acknowledge, the abort, the disable while a byte is in flight, and the two-frame end of message.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
   typedef enum logic [1:0] {SND_IDLE, SND_BUSY, SND_DONE} snd_st_e;
   typedef enum logic [1:0] {RCV_IDLE, RCV_CMP, RCV_HOLD, RCV_REL} rcv_st_e;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_TXD  = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;
   localparam logic [1:0] A_RXD  = 2'd3;
   localparam int CTRL_BITS = 4;
   localparam int STAT_BITS = 6;
endpackage

// File: rtl/mon_hs_snd.sv
module mon_hs_snd
   import mon_hs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_i,
   input  logic              en_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              far_ack_i,
   output logic              hs_o,
   output logic [DATA_W-1:0] data_o,
   output logic [DATA_W-1:0] hold_o,
   output logic              acked_o,
   output logic              abort_o,
   output logic              busy_o
);
   snd_st_e           st;
   logic              pend, low_seen;
   logic [DATA_W-1:0] hold, cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SND_IDLE; pend <= 1'b0; low_seen <= 1'b0; busy_o <= 1'b0;
         hold <= '0; cur <= '1; acked_o <= 1'b0; abort_o <= 1'b0;
      end else begin
         acked_o <= 1'b0;
         abort_o <= 1'b0;
         if (load_i) hold <= load_data_i;
         if (!en_i) begin
            st <= SND_IDLE; pend <= 1'b0; low_seen <= 1'b0; busy_o <= 1'b0;
         end else begin
            if (frame_i) begin
               case (st)
                  SND_IDLE: if (pend) begin
                     st <= SND_BUSY; cur <= hold; pend <= 1'b0; low_seen <= 1'b0;
                  end
                  SND_BUSY: if (!far_ack_i) begin
                     if (low_seen) begin st <= SND_DONE; acked_o <= 1'b1; end
                     else low_seen <= 1'b1;
                  end else if (low_seen) begin
                     st <= SND_IDLE; abort_o <= 1'b1; busy_o <= 1'b0; pend <= 1'b0;
                  end
                  SND_DONE: if (far_ack_i) begin
                     if (pend) begin
                        st <= SND_BUSY; cur <= hold; pend <= 1'b0; low_seen <= 1'b0;
                     end else begin
                        st <= SND_IDLE; busy_o <= 1'b0;
                     end
                  end
                  default: st <= SND_IDLE;
               endcase
            end
            if (load_i) begin pend <= 1'b1; busy_o <= 1'b1; end
         end
      end
   end

   assign hs_o   = !(en_i && st == SND_BUSY);
   assign data_o = (st == SND_BUSY) ? cur : '1;
   assign hold_o = hold;

   // R3
   snd_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_o && $past(!hs_o)) |-> $stable(data_o));
   // R4
   snd_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acked_o |-> ($past(frame_i) && !$past(far_ack_i)));
   // R2
   snd_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_i) |=> !busy_o);
endmodule

// File: rtl/mon_hs_rcv.sv
module mon_hs_rcv
   import mon_hs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_i,
   input  logic              en_i,
   input  logic              far_snd_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              hs_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              got_o,
   output logic              end_o
);
   rcv_st_e           st;
   logic              hi_seen;
   logic [DATA_W-1:0] cand;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RCV_IDLE; hi_seen <= 1'b0; cand <= '0; rx_data_o <= '0;
         got_o <= 1'b0; end_o <= 1'b0;
      end else begin
         got_o <= 1'b0;
         end_o <= 1'b0;
         if (!en_i) begin
            st <= RCV_IDLE; hi_seen <= 1'b0;
         end else if (frame_i) begin
            case (st)
               RCV_IDLE: if (!far_snd_i) begin cand <= data_i; st <= RCV_CMP; end
               RCV_CMP: if (far_snd_i) st <= RCV_IDLE;
                  else if (data_i == cand) begin
                     rx_data_o <= data_i; got_o <= 1'b1; st <= RCV_HOLD;
                  end else cand <= data_i;
               RCV_HOLD: if (far_snd_i) begin st <= RCV_REL; hi_seen <= 1'b0; end
               RCV_REL: if (!far_snd_i) begin cand <= data_i; st <= RCV_CMP; end
                  else if (hi_seen) begin end_o <= 1'b1; st <= RCV_IDLE; end
                  else hi_seen <= 1'b1;
               default: st <= RCV_IDLE;
            endcase
         end
      end
   end

   assign hs_o = !(en_i && st == RCV_HOLD);

   // R9
   rcv_ack_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_o) |-> ($past(frame_i) && !$past(far_snd_i)));
   // R10
   rcv_got_holds_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (got_o && en_i) |-> !hs_o);
endmodule

// File: rtl/mon_hs_regs.sv
module mon_hs_regs
   import mon_hs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o,
   output logic              snd_en_o,
   output logic              rcv_en_o,
   output logic              load_o,
   input  logic [DATA_W-1:0] hold_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              acked_i,
   input  logic              abort_i,
   input  logic              busy_i,
   input  logic              got_i,
   input  logic              end_i
);
   logic [CTRL_BITS-1:0] ctrl;
   logic                 f_ack, f_abt, f_got, f_end, rd_stat;
   logic [STAT_BITS-1:0] stat;

   assign rd_stat = rd_i && addr_i == A_STAT;
   assign load_o  = wr_i && addr_i == A_TXD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0; f_ack <= 1'b0; f_abt <= 1'b0; f_got <= 1'b0; f_end <= 1'b0;
      end else begin
         if (wr_i && addr_i == A_CTRL) ctrl <= wdata_i[CTRL_BITS-1:0];
         f_ack <= acked_i | (f_ack & !rd_stat);
         f_abt <= abort_i | (f_abt & !rd_stat);
         f_got <= got_i   | (f_got & !rd_stat);
         f_end <= end_i   | (f_end & !rd_stat);
      end
   end

   assign snd_en_o = ctrl[0];
   assign rcv_en_o = ctrl[2];
   assign stat     = {f_end, f_got, 1'b0, busy_i, f_abt, f_ack};
   assign irq_o    = (ctrl[1] & (f_ack | f_abt)) | (ctrl[3] & (f_got | f_end));

   always_comb begin
      case (addr_i)
         A_CTRL:  rdata_o = DATA_W'(ctrl);
         A_TXD:   rdata_o = hold_i;
         A_STAT:  rdata_o = DATA_W'(stat);
         default: rdata_o = rx_data_i;
      endcase
   end

   // R12
   rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_stat) && !$past(acked_i | abort_i | got_i | end_i))
      |-> !(f_ack | f_abt | f_got | f_end));
   // R13
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[1] && !ctrl[3]) |-> !irq_o);
endmodule

// File: rtl/mon_hs_ctrl.sv
module mon_hs_ctrl
   import mon_hs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_i,
   input  logic              far_snd_hs_i,
   input  logic              far_ack_hs_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              snd_hs_o,
   output logic              ack_hs_o,
   output logic [DATA_W-1:0] data_o,
   input  logic [1:0]        host_addr_i,
   input  logic              host_wr_i,
   input  logic              host_rd_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   output logic [DATA_W-1:0] host_rdata_o,
   output logic              irq_o
);
   localparam int MIN_W = (CTRL_BITS > STAT_BITS) ? CTRL_BITS : STAT_BITS;

   generate
      if (DATA_W < MIN_W) begin : g_width_chk
         $error("mon_hs_ctrl: DATA_W must hold the status word");
      end
   endgenerate

   logic              snd_en, rcv_en, load, acked, abort, busy, got, endm;
   logic [DATA_W-1:0] hold, rx_data;

   mon_hs_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr_i(host_addr_i), .wr_i(host_wr_i),
      .rd_i(host_rd_i), .wdata_i(host_wdata_i), .rdata_o(host_rdata_o),
      .irq_o(irq_o), .snd_en_o(snd_en), .rcv_en_o(rcv_en), .load_o(load),
      .hold_i(hold), .rx_data_i(rx_data), .acked_i(acked), .abort_i(abort),
      .busy_i(busy), .got_i(got), .end_i(endm)
   );

   mon_hs_snd #(.DATA_W(DATA_W)) u_snd (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .en_i(snd_en),
      .load_i(load), .load_data_i(host_wdata_i), .far_ack_i(far_ack_hs_i),
      .hs_o(snd_hs_o), .data_o(data_o), .hold_o(hold), .acked_o(acked),
      .abort_o(abort), .busy_o(busy)
   );

   mon_hs_rcv #(.DATA_W(DATA_W)) u_rcv (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .en_i(rcv_en),
      .far_snd_i(far_snd_hs_i), .data_i(data_i), .hs_o(ack_hs_o),
      .rx_data_o(rx_data), .got_o(got), .end_o(endm)
   );

   // R1
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snd_hs_o |-> (data_o == '1 || $past(!snd_hs_o)));
endmodule

// File: tb/sim_mon_hs_ctrl.sv
`timescale 1ns/1ps
module sim_mon_hs_ctrl;
   localparam int DW = 8;
   logic          clk = 1'b0, rst_n = 1'b0, frame_i = 1'b0;
   logic          far_snd = 1'b1, far_ack = 1'b1, wr = 1'b0, rd = 1'b0;
   logic [DW-1:0] din = '0, wdata = '0, rdata, dout;
   logic [1:0]    addr = '0;
   logic          snd_hs, ack_hs, irq;
   int            checks = 0, errors = 0, cyc = 0;

   always #2.5 clk = ~clk;

   mon_hs_ctrl #(.DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .far_snd_hs_i(far_snd),
      .far_ack_hs_i(far_ack), .data_i(din), .snd_hs_o(snd_hs), .ack_hs_o(ack_hs),
      .data_o(dout), .host_addr_i(addr), .host_wr_i(wr), .host_rd_i(rd),
      .host_wdata_i(wdata), .host_rdata_o(rdata), .irq_o(irq)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [7:0] stat_exp(bit ack, bit abt, bit busy, bit got, bit endm);
      return {2'b00, endm, got, 1'b0, busy, abt, ack};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic frame(input logic s, input logic a, input logic [DW-1:0] d);
      @(negedge clk); frame_i = 1'b1; far_snd = s; far_ack = a; din = d;
      @(negedge clk); frame_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic hwr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic hrd(input logic [1:0] a, output logic [DW-1:0] v);
      @(negedge clk); rd = 1'b1; addr = a; #1 v = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   initial begin
      logic [DW-1:0] v;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 snd_hs", snd_hs, 1); chk("R1 ack_hs", ack_hs, 1);
      chk("R1 data", dout, 8'hFF); chk("R1 irq", irq, 0);
      hrd(2, v); chk("R1 status", v, 0);

      // R2 byte written while send disabled is dropped
      hwr(1, 8'h99);
      frame(1, 1, 0); chk("R2 off snd_hs", snd_hs, 1);
      hrd(2, v); chk("R2 off busy", v, stat_exp(0,0,0,0,0));
      hwr(0, 8'h03);
      frame(1, 1, 0); chk("R2 dropped not sent", snd_hs, 1);

      // R3 send and repeat
      hwr(1, 8'hA5);
      hrd(2, v); chk("R7 busy on load", v, stat_exp(0,0,1,0,0));
      frame(1, 1, 0); chk("R3 snd_hs low", snd_hs, 0); chk("R3 data", dout, 8'hA5);
      for (int i = 0; i < 3; i++) begin
         frame(1, 1, 0); chk("R3 repeat hs", snd_hs, 0); chk("R3 repeat data", dout, 8'hA5);
      end
      // R4 acknowledge needs two low frames
      frame(1, 0, 0); chk("R4 one low not ack", snd_hs, 0);
      frame(1, 0, 0); chk("R4 ack hs", snd_hs, 1); chk("R13 irq tx", irq, 1);
      hrd(2, v); chk("R4 ack flag", v, stat_exp(1,0,1,0,0));
      chk("R12 irq cleared", irq, 0);
      // R5 next byte at release
      hwr(1, 8'h3C);
      frame(1, 0, 0); chk("R5 wait release", snd_hs, 1);
      frame(1, 1, 0); chk("R5 next sent", snd_hs, 0); chk("R5 next data", dout, 8'h3C);
      frame(1, 0, 0); frame(1, 0, 0); chk("R4 second ack", snd_hs, 1);
      frame(1, 1, 0); chk("R5 end idle data", dout, 8'hFF);
      hrd(2, v); chk("R5 end busy clear", v, stat_exp(1,0,0,0,0));
      hrd(2, v); chk("R12 read clears", v, 0);

      // R6 abort
      hwr(1, 8'h77);
      frame(1, 1, 0); frame(1, 0, 0); frame(1, 1, 0);
      chk("R6 abort hs", snd_hs, 1); chk("R13 irq abort", irq, 1);
      hrd(2, v); chk("R6 abort flag", v, stat_exp(0,1,0,0,0));

      // R2 disable mid-transfer
      hwr(1, 8'h11);
      frame(1, 1, 0); chk("R2 sending", snd_hs, 0);
      hwr(0, 8'h00); chk("R2 forced idle", snd_hs, 1);
      frame(1, 1, 0); chk("R2 stays idle", snd_hs, 1);
      hrd(2, v); chk("R7 busy off", v, 0);

      // random send with stalls
      hwr(0, 8'h03);
      for (int n = 0; n < 12; n++) begin
         logic [DW-1:0] b = DW'($urandom);
         int k = $urandom % 4;
         hwr(1, b);
         frame(1, 1, 0);
         for (int s = 0; s < k; s++) frame(1, 1, 0);
         chk("R3 rnd data", dout, b); chk("R3 rnd hs", snd_hs, 0);
         frame(1, 0, 0); frame(1, 0, 0); chk("R4 rnd ack", snd_hs, 1);
         frame(1, 1, 0);
         hrd(2, v); chk("R5 rnd end", v, stat_exp(1,0,0,0,0));
      end

      // receive side
      hwr(0, 8'h0C);
      frame(0, 1, 8'hE1); chk("R9 one frame", ack_hs, 1);
      frame(0, 1, 8'hF2); chk("R9 mismatch", ack_hs, 1);
      frame(0, 1, 8'hF2); chk("R9 accepted", ack_hs, 0); chk("R13 irq rx", irq, 1);
      hrd(3, v); chk("R9 rx data", v, 8'hF2);
      hrd(2, v); chk("R9 got flag", v, stat_exp(0,0,0,1,0));
      frame(0, 1, 8'hF2); frame(0, 1, 8'hF2);
      chk("R10 held", ack_hs, 0);
      hrd(2, v); chk("R10 no duplicate", v, 0);
      frame(1, 1, 0); chk("R10 released", ack_hs, 1);
      frame(0, 1, 8'h5A); frame(0, 1, 8'h5A); chk("R9 second", ack_hs, 0);
      frame(1, 1, 0); frame(1, 1, 0);
      hrd(2, v); chk("R11 not yet end", v, stat_exp(0,0,0,1,0));
      frame(1, 1, 0);
      hrd(2, v); chk("R11 end flag", v, stat_exp(0,0,0,0,1));

      // random receive with mismatching frames
      for (int n = 0; n < 16; n++) begin
         logic [DW-1:0] b = DW'($urandom);
         int g = $urandom % 3;
         for (int k = 0; k < g; k++) begin
            frame(0, 1, b ^ DW'(k + 1)); chk("R9 rnd no early", ack_hs, 1);
         end
         frame(0, 1, b); frame(0, 1, b);
         chk("R9 rnd ack", ack_hs, 0);
         hrd(3, v); chk("R9 rnd data", v, b);
         hrd(2, v); chk("R9 rnd flag", v, stat_exp(0,0,0,1,0));
         frame(1, 1, 0); chk("R10 rnd release", ack_hs, 1);
      end

      // R13 interrupt masked
      hwr(0, 8'h04);
      frame(0, 1, 8'h42); frame(0, 1, 8'h42);
      chk("R13 masked irq", irq, 0);
      hrd(2, v); chk("R13 flag still set", v, stat_exp(0,0,0,1,0));

      // R8 receive disabled
      hwr(0, 8'h00);
      chk("R8 forced idle", ack_hs, 1);
      frame(0, 1, 8'h66); frame(0, 1, 8'h66);
      chk("R8 no ack", ack_hs, 1);
      hrd(2, v); chk("R8 no flag", v, 0);
      hrd(3, v); chk("R8 rx unchanged", v, 8'h42);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule